// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps every instruction that has been dispatched but not yet retired, in program order, in a circular store. At dispatch a slot is allocated at the tail. The slot records three things: the physical register that held the destination's value before this instruction was renamed, whether that mapping is meaningful, and whether the instruction is a branch. The dispatch port returns the slot number. Execution units later report completion by slot number, in any order, and may flag the result as a mispredicted branch or a fault.

Retirement happens only at the head, one entry per cycle, and only once the head entry has completed. A normal retirement hands the recorded previous physical register to the rename free list. If the head is a mispredicted branch, it retires and every younger entry is discarded. If the head faulted, every younger entry is discarded as well, and the faulting entry releases no register. After either kind of flush the buffer is empty, and the next dispatch lands in the slot just after the flushing entry. A wrap bit on each pointer tells a full buffer from an empty one. The depth must be a power of two.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty: `rob_empty`=1, `disp_ready`=1, `disp_index`=0, and no commit, free or squash output is asserted.
- R2: Each accepted dispatch takes the slot shown on `disp_index` in that cycle. Slots are handed out consecutively, modulo DEPTH.
- R3: With DEPTH uncommitted entries, `disp_ready` is 0 and a dispatch request is ignored.
- R4: An entry that has not completed never commits. A completion reported for a younger entry does not let the head commit.
- R5: Commit is in order from the head, at most one entry per cycle. `commit_index` names the slot, and commit is asserted in the cycle after the head's completion is recorded.
- R6: On a normal commit whose recorded previous mapping is valid, `free_valid`=1 and `free_preg` carries that register. When the mapping is invalid, `free_valid`=0.
- R7: When the head has completed as a branch flagged mispredicted, it commits with `squash_valid`=1 and `squash_fault`=0, it frees its valid previous register, and all younger entries are dropped. The next cycle shows `rob_empty`=1 and `disp_index` = the branch slot + 1.
- R8: When the head has completed with the fault flag, `squash_valid`=1 and `squash_fault`=1, no register is freed, and all younger entries are dropped.
- R9: A mispredict flag reported for an entry that is not a branch has no effect, and the entry commits normally without a squash.
- R10: A completion whose slot holds no live entry is ignored and produces no commit.
- R11: In a squash cycle `disp_ready` is 0 and a dispatch request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_old_vld | input | 1 | Previous destination mapping is meaningful |
| disp_old_preg | input | PREG_W | Previous physical register of the destination |
| disp_is_branch | input | 1 | Dispatched instruction is a branch |
| disp_ready | output | 1 | A dispatch is accepted this cycle |
| disp_index | output | log2(DEPTH) | Slot given to the dispatch |
| cmp_valid | input | 1 | Completion report |
| cmp_index | input | log2(DEPTH) | Slot being completed |
| cmp_mispredict | input | 1 | Branch resolved as mispredicted |
| cmp_fault | input | 1 | Instruction faulted |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_index | output | log2(DEPTH) | Slot of the head entry |
| free_valid | output | 1 | A register is released to the free list |
| free_preg | output | PREG_W | Register being released |
| squash_valid | output | 1 | Younger entries are discarded this cycle |
| squash_fault | output | 1 | The squash comes from a fault |
| rob_empty | output | 1 | No uncommitted entries |

## Verification
On every cycle, the assertions check the following: a commit needs a completed head; the head steps by exactly one slot after a commit; a squash leaves the buffer empty on the next cycle; a fault never frees a register; the tail does not move while dispatch is refused; and an empty buffer never commits. Other properties can only be shown by the bench's scenarios, through its cycle-by-cycle reference model. These are the slot values handed out across wrap-around, the register value sent to the free list, the out-of-order completion patterns, the mispredict flag being ignored on a non-branch, and stray completions to dead slots.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    RK_IDLE        = 2'd0,
    RK_RETIRE      = 2'd1,
    RK_FLUSH_BR    = 2'd2,
    RK_FLUSH_FAULT = 2'd3
  } retire_kind_e;

  // Decide what the head slot does this cycle; fault outranks mispredict.
  function automatic retire_kind_e classify_head(input logic live, input logic done,
                                                 input logic is_br, input logic mis,
                                                 input logic fault);
    if (!(live && done)) return RK_IDLE;
    if (fault)           return RK_FLUSH_FAULT;
    if (is_br && mis)    return RK_FLUSH_BR;
    return RK_RETIRE;
  endfunction

  // Wrap-bit pointer comparisons.
  function automatic logic ptrs_full(input logic [31:0] h, input logic [31:0] t, input int idx_w);
    logic [31:0] mask;
    mask = (32'd1 << idx_w) - 32'd1;
    return ((h & mask) == (t & mask)) && (h[idx_w] != t[idx_w]);
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_head,
  input  logic             adv_tail,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W:0]   tail_ptr,
  output logic             full,
  output logic             empty
);
  import rob_pkg::*;
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, tail_q, head_inc, tail_inc;

  assign head_inc = head_q + PTR_W'(1);
  assign tail_inc = tail_q + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (adv_head) head_q <= head_inc;
      if (flush)         tail_q <= head_inc;
      else if (adv_tail) tail_q <= tail_inc;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign tail_ptr = tail_q;
  assign empty    = (head_q == tail_q);
  assign full     = ptrs_full(32'(head_q), 32'(tail_q), IDX_W);

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_old_vld,
  input  logic [PREG_W-1:0] wr_old_preg,
  input  logic              wr_is_br,
  input  logic              cmp_en,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic              cmp_mis,
  input  logic              cmp_fault,
  input  logic              ret_en,
  input  logic              flush_all,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_live,
  output logic              rd_done,
  output logic              rd_is_br,
  output logic              rd_mis,
  output logic              rd_fault,
  output logic              rd_old_vld,
  output logic [PREG_W-1:0] rd_old_preg
);
  logic              live_q  [DEPTH];
  logic              done_q  [DEPTH];
  logic              br_q    [DEPTH];
  logic              mis_q   [DEPTH];
  logic              fault_q [DEPTH];
  logic              ovld_q  [DEPTH];
  logic [PREG_W-1:0] opreg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_wr, hit_cmp, hit_ret;
    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign hit_cmp = cmp_en && (cmp_idx == IDX_W'(g)) && live_q[g];
    assign hit_ret = ret_en && (rd_idx  == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[g]  <= 1'b0;
        done_q[g]  <= 1'b0;
        br_q[g]    <= 1'b0;
        mis_q[g]   <= 1'b0;
        fault_q[g] <= 1'b0;
        ovld_q[g]  <= 1'b0;
        opreg_q[g] <= '0;
      end else begin
        if (flush_all)    live_q[g] <= 1'b0;
        else if (hit_ret) live_q[g] <= 1'b0;
        else if (hit_wr)  live_q[g] <= 1'b1;

        if (hit_wr) begin
          done_q[g]  <= 1'b0;
          mis_q[g]   <= 1'b0;
          fault_q[g] <= 1'b0;
          br_q[g]    <= wr_is_br;
          ovld_q[g]  <= wr_old_vld;
          opreg_q[g] <= wr_old_preg;
        end else if (hit_cmp) begin
          done_q[g]  <= 1'b1;
          mis_q[g]   <= cmp_mis;
          fault_q[g] <= cmp_fault;
        end
      end
    end
  end

  assign rd_live     = live_q[rd_idx];
  assign rd_done     = done_q[rd_idx];
  assign rd_is_br    = br_q[rd_idx];
  assign rd_mis      = mis_q[rd_idx];
  assign rd_fault    = fault_q[rd_idx];
  assign rd_old_vld  = ovld_q[rd_idx];
  assign rd_old_preg = opreg_q[rd_idx];

endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl (
  input  logic head_live,
  input  logic head_done,
  input  logic head_is_br,
  input  logic head_mis,
  input  logic head_fault,
  input  logic head_old_vld,
  input  logic buf_full,
  input  logic disp_valid,
  output logic commit,
  output logic flush,
  output logic flush_fault,
  output logic free_en,
  output logic disp_ready,
  output logic disp_accept
);
  import rob_pkg::*;

  retire_kind_e kind;

  always_comb begin
    kind        = classify_head(head_live, head_done, head_is_br, head_mis, head_fault);
    commit      = (kind != RK_IDLE);
    flush       = (kind == RK_FLUSH_BR) || (kind == RK_FLUSH_FAULT);
    flush_fault = (kind == RK_FLUSH_FAULT);
    free_en     = commit && !flush_fault && head_old_vld;
    disp_ready  = !buf_full && !flush;
    disp_accept = disp_ready && disp_valid;
  end

endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit #(
  parameter int DEPTH  = 16,
  parameter int PREG_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic                     disp_old_vld,
  input  logic [PREG_W-1:0]        disp_old_preg,
  input  logic                     disp_is_branch,
  output logic                     disp_ready,
  output logic [$clog2(DEPTH)-1:0] disp_index,
  input  logic                     cmp_valid,
  input  logic [$clog2(DEPTH)-1:0] cmp_index,
  input  logic                     cmp_mispredict,
  input  logic                     cmp_fault,
  output logic                     commit_valid,
  output logic [$clog2(DEPTH)-1:0] commit_index,
  output logic                     free_valid,
  output logic [PREG_W-1:0]        free_preg,
  output logic                     squash_valid,
  output logic                     squash_fault,
  output logic                     rob_empty
);
  localparam int IDX_W = $clog2(DEPTH);

  // Named internal events, also observed by the bound checker.
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [IDX_W:0]   tail_ptr;
  logic             rob_full;
  logic             head_live, head_done, head_br, head_mis, head_flt, head_ovld;
  logic             do_commit, do_flush, do_flush_fault, do_free, do_accept, can_disp;

  rob_ptr_ctrl #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_head (do_commit),
    .adv_tail (do_accept),
    .flush    (do_flush),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .tail_ptr (tail_ptr),
    .full     (rob_full),
    .empty    (rob_empty)
  );

  rob_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PREG_W(PREG_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (do_accept),
    .wr_idx      (tail_idx),
    .wr_old_vld  (disp_old_vld),
    .wr_old_preg (disp_old_preg),
    .wr_is_br    (disp_is_branch),
    .cmp_en      (cmp_valid),
    .cmp_idx     (cmp_index),
    .cmp_mis     (cmp_mispredict),
    .cmp_fault   (cmp_fault),
    .ret_en      (do_commit),
    .flush_all   (do_flush),
    .rd_idx      (head_idx),
    .rd_live     (head_live),
    .rd_done     (head_done),
    .rd_is_br    (head_br),
    .rd_mis      (head_mis),
    .rd_fault    (head_flt),
    .rd_old_vld  (head_ovld),
    .rd_old_preg (free_preg)
  );

  rob_retire_ctrl u_ret (
    .head_live    (head_live),
    .head_done    (head_done),
    .head_is_br   (head_br),
    .head_mis     (head_mis),
    .head_fault   (head_flt),
    .head_old_vld (head_ovld),
    .buf_full     (rob_full),
    .disp_valid   (disp_valid),
    .commit       (do_commit),
    .flush        (do_flush),
    .flush_fault  (do_flush_fault),
    .free_en      (do_free),
    .disp_ready   (can_disp),
    .disp_accept  (do_accept)
  );

  assign disp_ready   = can_disp;
  assign disp_index   = tail_idx;
  assign commit_valid = do_commit;
  assign commit_index = head_idx;
  assign free_valid   = do_free;
  assign squash_valid = do_flush;
  assign squash_fault = do_flush_fault;

endmodule

// File: rtl/rob_commit_checker.sv
module rob_commit_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic             commit_valid,
  input logic [IDX_W-1:0] head_idx,
  input logic             head_done,
  input logic             free_valid,
  input logic             squash_valid,
  input logic             squash_fault,
  input logic             rob_empty,
  input logic             rob_full,
  input logic [IDX_W:0]   tail_ptr
);
  AST_COMMIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> head_done);  // R4
  AST_HEAD_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head_idx == $past(head_idx) + IDX_W'(1));  // R5
  AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> rob_empty);  // R7
  AST_FAULT_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    squash_fault |-> !free_valid);  // R8
  AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_full && disp_valid && !squash_valid) |=> tail_ptr == $past(tail_ptr));  // R3
  AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> !commit_valid);  // R10
  AST_SQUASH_BLOCKS_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !disp_ready);  // R11
endmodule

bind rob_commit_unit rob_commit_checker #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .disp_valid   (disp_valid),
  .disp_ready   (disp_ready),
  .commit_valid (commit_valid),
  .head_idx     (head_idx),
  .head_done    (head_done),
  .free_valid   (free_valid),
  .squash_valid (squash_valid),
  .squash_fault (squash_fault),
  .rob_empty    (rob_empty),
  .rob_full     (rob_full),
  .tail_ptr     (tail_ptr)
);

// File: tb/rob_commit_unit_test.sv
module rob_commit_unit_test;
  localparam int D  = 16;
  localparam int IW = 4;
  localparam int PW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 0, disp_old_vld = 0, disp_is_branch = 0;
  logic [PW-1:0] disp_old_preg = '0;
  logic cmp_valid = 0, cmp_mispredict = 0, cmp_fault = 0;
  logic [IW-1:0] cmp_index = '0;
  logic disp_ready, commit_valid, free_valid, squash_valid, squash_fault, rob_empty;
  logic [IW-1:0] disp_index, commit_index;
  logic [PW-1:0] free_preg;

  int vectors = 0, miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  rob_commit_unit #(.DEPTH(D), .PREG_W(PW)) uut (.*);

  // Behavioural reference: slot arrays plus head slot and occupancy.
  int mh = 0, mc = 0;
  bit m_done[D], m_mis[D], m_flt[D], m_br[D], m_ov[D];
  int m_op[D];

  function automatic bit e_hrdy();  return mc > 0 && m_done[mh]; endfunction
  function automatic bit e_flt();   return e_hrdy() && m_flt[mh]; endfunction
  function automatic bit e_sq();    return e_hrdy() && (m_flt[mh] || (m_br[mh] && m_mis[mh])); endfunction
  function automatic bit e_free();  return e_hrdy() && !m_flt[mh] && m_ov[mh]; endfunction
  function automatic bit e_ready(); return mc < D && !e_sq(); endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 disp_ready", int'(disp_ready), int'(e_ready()));
    chk("R2 disp_index", int'(disp_index), (mh + mc) % D);
    chk("R1 rob_empty", int'(rob_empty), int'(mc == 0));
    chk("R5 commit_valid", int'(commit_valid), int'(e_hrdy()));
    chk("R5 commit_index", int'(commit_index), mh);
    chk("R6 free_valid", int'(free_valid), int'(e_free()));
    if (e_free()) chk("R6 free_preg", int'(free_preg), m_op[mh]);
    chk("R7 squash_valid", int'(squash_valid), int'(e_sq()));
    chk("R8 squash_fault", int'(squash_fault), int'(e_flt()));
  endtask

  task automatic model_step();
    bit hr, sq, acc;
    int off;
    hr  = e_hrdy();
    sq  = e_sq();
    acc = disp_valid && e_ready();
    off = (int'(cmp_index) - mh + D) % D;
    if (cmp_valid && off < mc) begin
      m_done[cmp_index] = 1;
      m_mis[cmp_index]  = cmp_mispredict;
      m_flt[cmp_index]  = cmp_fault;
    end
    if (acc) begin
      int t;
      t = (mh + mc) % D;
      m_done[t] = 0; m_mis[t] = 0; m_flt[t] = 0;
      m_br[t] = disp_is_branch; m_ov[t] = disp_old_vld; m_op[t] = int'(disp_old_preg);
    end
    if (sq) begin
      mh = (mh + 1) % D; mc = 0;
    end else begin
      if (hr) begin mh = (mh + 1) % D; mc--; end
      if (acc) mc++;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    disp_valid = 0; cmp_valid = 0; cmp_mispredict = 0; cmp_fault = 0;
  endtask

  task automatic disp(input bit ov, input int op, input bit br, output int idx);
    idle();
    disp_valid = 1; disp_old_vld = ov; disp_old_preg = PW'(op); disp_is_branch = br;
    idx = int'(disp_index);
    cyc();
    idle();
  endtask

  task automatic comp(input int idx, input bit mis, input bit flt);
    idle();
    cmp_valid = 1; cmp_index = IW'(idx); cmp_mispredict = mis; cmp_fault = flt;
    cyc();
    idle();
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int a, b, c, br, y1, y2;
    int ids[D];
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_all();
    chk("R1 reset empty", int'(rob_empty), 1);
    chk("R1 reset ready", int'(disp_ready), 1);

    // R2/R4/R5/R6: out-of-order completion, in-order commit
    disp(1, 11, 0, a); disp(0, 22, 0, b); disp(1, 33, 0, c);
    chk("R2 consecutive", (b - a + D) % D, 1);
    comp(c, 0, 0);
    chk("R4 younger done no commit", int'(commit_valid), 0);
    comp(b, 0, 0);
    comp(a, 0, 0);
    chk("R5 head commits", int'(commit_valid), 1);
    chk("R6 free reg", int'(free_preg), 11);
    cyc();
    chk("R6 invalid old no free", int'(free_valid), 0);
    cyc(); cyc();
    chk("R5 drained", int'(rob_empty), 1);

    // R3: fill, blocked dispatch, then reverse-order completion
    for (int i = 0; i < D; i++) disp(1, i + 40, 0, ids[i]);
    chk("R3 full not ready", int'(disp_ready), 0);
    disp(1, 99, 0, a);
    chk("R3 ignored dispatch", int'(disp_ready), 0);
    for (int i = D - 1; i >= 0; i--) comp(ids[i], 0, 0);
    for (int i = 0; i < D + 2; i++) cyc();
    chk("R5 all committed", int'(rob_empty), 1);

    // R7/R11: mispredicted branch with younger work, dispatch held during squash
    disp(1, 5, 1, br); disp(1, 6, 0, y1); disp(1, 7, 0, y2);
    comp(y2, 0, 0); comp(y1, 0, 0);
    comp(br, 1, 0);
    chk("R7 squash", int'(squash_valid), 1);
    chk("R11 ready low in squash", int'(disp_ready), 0);
    disp_valid = 1; disp_old_vld = 1; disp_old_preg = 7'd9; disp_is_branch = 0;
    cyc(); idle();
    chk("R7 empty after squash", int'(rob_empty), 1);
    chk("R7 next slot", int'(disp_index), (br + 1) % D);

    // R8: fault at head with a younger entry
    disp(1, 12, 0, a); disp(1, 13, 0, b);
    comp(b, 0, 0); comp(a, 0, 1);
    chk("R8 fault squash", int'(squash_fault), 1);
    chk("R8 no free", int'(free_valid), 0);
    cyc();

    // R9: mispredict flag on a non-branch
    disp(1, 20, 0, a);
    comp(a, 1, 0);
    chk("R9 commits", int'(commit_valid), 1);
    chk("R9 no squash", int'(squash_valid), 0);
    cyc();

    // R10: completion to a dead slot
    comp(int'(commit_index), 0, 0);
    chk("R10 no commit", int'(commit_valid), 0);
    comp((int'(commit_index) + 3) % D, 1, 1);
    cyc();
    chk("R10 still empty", int'(rob_empty), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule